// File: doc/BRIEF.md
# Dual-Port Audio Interrupt Combiner

This block merges the service requests of two audio ports, each with a transmit and a receive FIFO, into a single CPU interrupt line. Each request line is edge-captured into a sticky status bit. A source reaches the interrupt only when software has set its bit in two separate enable registers: an event-enable register and a mask register. Software clears serviced sources by writing zero to their status bits.

A reset-control register drives the two port reset outputs. It also holds a global reset and an interrupt-logic reset, each active while its bit is zero. A small state machine tracks the two internal reset fields. It has four states: RUN (both released), INT_HOLD (interrupt logic held), GLB_HOLD (global reset held) and ALL_HOLD (both held). A write to the reset register moves the machine directly to the state named by the written bit 0 and bit 4. The usual service sequence is to pulse the interrupt reset low and then high, handle the sources, and then write zero to the status register.

Top module: `aud_irq_merge`

## Requirements
- R1: Sources use fixed bit positions in the status, event-enable and mask registers: port A transmit at bit 0, port A receive at bit 4, port B transmit at bit 8 and port B receive at bit 12. Word addresses are status 0, event-enable 1, mask 2 and reset-control 3.
- R2: A rising edge on a request line sets its status bit on that clock edge. The bit stays set after the request drops. A request held high sets the bit only once, so after a clear it stays clear until the line rises again.
- R3: `irq_o` is a register. It goes high one clock after some status bit is set while the same bit is set in both the event-enable and the mask register. It stays low if either enable is missing.
- R4: Writing the status register with 0 at a source position clears that bit, and writing 1 leaves it unchanged. Writing zero to the whole register clears every source. A rising edge in the same cycle as a clearing write wins, and the bit ends up set.
- R5: While reset-control bit 4 is 0 (INT_HOLD or ALL_HOLD), status is cleared, new edges are not captured and `irq_o` is low. The enable registers keep their values. Writing 1 to bit 4 resumes capture.
- R6: While reset-control bit 0 is 0 (GLB_HOLD or ALL_HOLD), status and both enable registers are cleared and held, and both port reset outputs are high.
- R7: `port_a_rst_o` is high while reset-control bit 8 is 0. `port_b_rst_o` is high while bit 12 is 0. The reset-control register reads back the bits written at positions 0, 4, 8 and 12.
- R8: Write data bits 31:24 are ignored. Bits outside the four defined positions of each register read as zero.
- R9: After hardware reset, status, event-enable and mask read 0, reset-control reads 0x1111, and `irq_o`, `port_a_rst_o` and `port_b_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Requests: [0] A transmit, [1] A receive, [2] B transmit, [3] B receive |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| irq_o | output | 1 | Combined interrupt |
| port_a_rst_o | output | 1 | Port A reset, active high |
| port_b_rst_o | output | 1 | Port B reset, active high |

## Verification
A status bit that is stuck or lost shows up on the next status read, and on `irq_o` one clock after the enables are both set. A reset-control state machine in the wrong state shows up within two clocks: `irq_o` stays low, edges stop being captured, or the enable registers read back as zero. The bench opens each enable separately to confirm that `irq_o` needs both. It also drives a request edge in the same cycle as a clearing write, and holds a request high across a clear to confirm that capture is edge-based.

// File: rtl/aud_irq_pkg.sv
`timescale 1ns/1ps
package aud_irq_pkg;
    // register word offsets
    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_EVMASK = 1;
    localparam int unsigned OFS_MASK   = 2;
    localparam int unsigned OFS_RESET  = 3;
    // reset-control field positions
    localparam int unsigned RB_GLB = 0;
    localparam int unsigned RB_INT = 4;
    localparam int unsigned RB_PA  = 8;
    localparam int unsigned RB_PB  = 12;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_INT_HOLD = 2'd1,
        ST_GLB_HOLD = 2'd2,
        ST_ALL_HOLD = 2'd3
    } rst_state_t;
endpackage

// File: rtl/aud_irq_src_cell.sv
`timescale 1ns/1ps
module aud_irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic hold_i,
    input  logic wr_i,
    input  logic keep_i,
    output logic status_o
);
    logic req_q;
    logic stat_q;
    logic rise;

    assign rise = req_i & ~req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            req_q <= req_i;
            if (hold_i)
                stat_q <= 1'b0;
            else if (rise)
                stat_q <= 1'b1;
            else if (wr_i && !keep_i)
                stat_q <= 1'b0;
        end
    end

    assign status_o = stat_q;
endmodule

// File: rtl/aud_irq_rst_ctrl.sv
`timescale 1ns/1ps
module aud_irq_rst_ctrl
    import aud_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic glb_rel_i,
    input  logic int_rel_i,
    output logic status_hold_o,
    output logic cfg_hold_o,
    output logic glb_rb_o,
    output logic int_rb_o
);
    rst_state_t state_q;
    rst_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case ({glb_rel_i, int_rel_i})
                2'b11: state_d = ST_RUN;
                2'b10: state_d = ST_INT_HOLD;
                2'b01: state_d = ST_GLB_HOLD;
                2'b00: state_d = ST_ALL_HOLD;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        status_hold_o = 1'b0;
        cfg_hold_o    = 1'b0;
        glb_rb_o      = 1'b1;
        int_rb_o      = 1'b1;
        unique case (state_q)
            ST_RUN: begin
            end
            ST_INT_HOLD: begin
                status_hold_o = 1'b1;
                int_rb_o      = 1'b0;
            end
            ST_GLB_HOLD: begin
                status_hold_o = 1'b1;
                cfg_hold_o    = 1'b1;
                glb_rb_o      = 1'b0;
            end
            ST_ALL_HOLD: begin
                status_hold_o = 1'b1;
                cfg_hold_o    = 1'b1;
                glb_rb_o      = 1'b0;
                int_rb_o      = 1'b0;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/aud_irq_merge.sv
`timescale 1ns/1ps
module aud_irq_merge
    import aud_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 4,
    parameter int unsigned SRC_STRIDE = 4,
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned VALID_W    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              port_a_rst_o,
    output logic              port_b_rst_o
);
    localparam int unsigned MAP_W = NUM_SRC * SRC_STRIDE;

    logic [VALID_W-1:0] wd;
    logic               wdata_unused;
    logic               wr_stat, wr_evm, wr_msk, wr_rst;
    logic [NUM_SRC-1:0] wfield;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] evm_q, msk_q;
    logic               pa_q, pb_q;
    logic               irq_q;
    logic               status_hold, cfg_hold, glb_rb, int_rb;
    logic [MAP_W-1:0]   map_stat, map_evm, map_msk, map_rst;

    assign wd           = bus_wdata[VALID_W-1:0];
    assign wdata_unused = ^bus_wdata;

    assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    assign wr_evm  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_EVMASK));
    assign wr_msk  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
    assign wr_rst  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_RESET));

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            wfield[i] = wd[i*SRC_STRIDE];
    end

    // one capture cell per source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        aud_irq_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_i[g]),
            .hold_i   (status_hold),
            .wr_i     (wr_stat),
            .keep_i   (wfield[g]),
            .status_o (status_q[g])
        );
    end

    aud_irq_rst_ctrl u_rst (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (wr_rst),
        .glb_rel_i     (wd[RB_GLB]),
        .int_rel_i     (wd[RB_INT]),
        .status_hold_o (status_hold),
        .cfg_hold_o    (cfg_hold),
        .glb_rb_o      (glb_rb),
        .int_rb_o      (int_rb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evm_q <= '0;
            msk_q <= '0;
        end else if (cfg_hold) begin
            evm_q <= '0;
            msk_q <= '0;
        end else begin
            if (wr_evm) evm_q <= wfield;
            if (wr_msk) msk_q <= wfield;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_q <= 1'b1;
            pb_q <= 1'b1;
        end else if (wr_rst) begin
            pa_q <= wd[RB_PA];
            pb_q <= wd[RB_PB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= !status_hold && (|(status_q & evm_q & msk_q));
    end

    assign irq_o        = irq_q;
    assign port_a_rst_o = ~pa_q | cfg_hold;
    assign port_b_rst_o = ~pb_q | cfg_hold;

    always_comb begin
        map_stat = '0;
        map_evm  = '0;
        map_msk  = '0;
        map_rst  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            map_stat[i*SRC_STRIDE] = status_q[i];
            map_evm[i*SRC_STRIDE]  = evm_q[i];
            map_msk[i*SRC_STRIDE]  = msk_q[i];
        end
        map_rst[RB_GLB] = glb_rb;
        map_rst[RB_INT] = int_rb;
        map_rst[RB_PA]  = pa_q;
        map_rst[RB_PB]  = pb_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                ADDR_W'(OFS_STATUS): bus_rdata = DATA_W'(map_stat);
                ADDR_W'(OFS_EVMASK): bus_rdata = DATA_W'(map_evm);
                ADDR_W'(OFS_MASK):   bus_rdata = DATA_W'(map_msk);
                ADDR_W'(OFS_RESET):  bus_rdata = DATA_W'(map_rst);
                default:             bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/aud_irq_merge_chk.sv
`timescale 1ns/1ps
module aud_irq_merge_chk
    import aud_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req_i,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_o,
    input logic               port_a_rst_o,
    input logic               port_b_rst_o,
    input logic [NUM_SRC-1:0] status,
    input logic               hold
);
    logic chk_unused;
    assign chk_unused = ^bus_wdata;

    logic wr_stat, wr_rst;
    assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    assign wr_rst  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_RESET));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        // R2: a captured rising edge sets status
        a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(req_i[g]) && !hold) |=> status[g]);
        // R4: status is sticky without a status write or hold
        a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[g] && !hold && !wr_stat) |=> status[g]);
    end

    // R3: interrupt only follows a set status bit
    a_r3_irq_has_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|status));

    // R5: interrupt logic held means interrupt low next cycle
    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !irq_o);

    // R6: global reset asserted drives both port resets
    a_r6_glb_ports: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rst && !bus_wdata[RB_GLB]) |=> (port_a_rst_o && port_b_rst_o));

    // R7: port A reset field cleared drives the port A reset
    a_r7_pa_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rst && !bus_wdata[RB_PA]) |=> port_a_rst_o);
endmodule

bind aud_irq_merge aud_irq_merge_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .irq_o        (irq_o),
    .port_a_rst_o (port_a_rst_o),
    .port_b_rst_o (port_b_rst_o),
    .status       (status_q),
    .hold         (status_hold)
);

// File: tb/aud_irq_merge_bench.sv
`timescale 1ns/1ps
module aud_irq_merge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, port_a_rst_o, port_b_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    aud_irq_merge u_aud_irq_merge (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .port_a_rst_o(port_a_rst_o), .port_b_rst_o(port_b_rst_o)
    );

    localparam logic [1:0] A_STAT = 2'd0, A_EVM = 2'd1, A_MSK = 2'd2, A_RST = 2'd3;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        req_i[idx] = 1'b1;
        @(negedge clk);
        req_i[idx] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R9 irq after reset", 32'(irq_o), 0);
        chk("R9 port A reset after reset", 32'(port_a_rst_o), 0);
        chk("R9 port B reset after reset", 32'(port_b_rst_o), 0);
        rd(A_STAT, v); chk("R9 status after reset", v, 32'h0);
        rd(A_EVM, v);  chk("R9 event enable after reset", v, 32'h0);
        rd(A_MSK, v);  chk("R9 mask after reset", v, 32'h0);
        rd(A_RST, v);  chk("R9 reset ctrl after reset", v, 32'h1111);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        pulse(0);
        rd(A_STAT, v); chk("R2 R1 A transmit sticky at bit 0", v, 32'h0001);
        @(negedge clk); req_i[3] = 1'b1;
        wait_cyc(1);
        rd(A_STAT, v); chk("R1 B receive at bit 12", v, 32'h1001);
        chk("R3 no irq with enables clear", 32'(irq_o), 0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(A_EVM, 32'h0001); wait_cyc(1);
        chk("R3 event enable alone gives no irq", 32'(irq_o), 0);
        wr(A_MSK, 32'h0001); wait_cyc(1);
        chk("R3 both enables give irq", 32'(irq_o), 1);
        rd(A_EVM, v); chk("R1 event enable readback", v, 32'h0001);
        wr(A_MSK, 32'h1000); wait_cyc(1);
        chk("R3 enables on different sources give no irq", 32'(irq_o), 0);
        wr(A_EVM, 32'h1000); wait_cyc(1);
        chk("R3 B receive fully enabled", 32'(irq_o), 1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); chk("R4 zero bit clears, ones keep", v, 32'h1000);
        wr(A_STAT, 32'h0000_EFFF);
        rd(A_STAT, v); chk("R2 held level does not re-set after clear", v, 32'h0);
        wait_cyc(1);
        chk("R4 irq drops after clear", 32'(irq_o), 0);
        @(negedge clk); req_i[3] = 1'b0;
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk);
        req_i[1] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; req_i[1] = 1'b0;
        rd(A_STAT, v); chk("R4 edge wins over same-cycle clear", v, 32'h0010);
        pulse(2);
        rd(A_STAT, v); chk("R1 A receive bit 4 and B transmit bit 8", v, 32'h0110);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R4 writing zero clears all", v, 32'h0);
    endtask

    task automatic t_int_reset();
        logic [31:0] v;
        wr(A_EVM, 32'h1111); wr(A_MSK, 32'h1111);
        pulse(0); wait_cyc(1);
        chk("R3 irq before interrupt reset", 32'(irq_o), 1);
        wr(A_RST, 32'h1101); wait_cyc(1);
        chk("R5 irq low during interrupt reset", 32'(irq_o), 0);
        rd(A_STAT, v); chk("R5 status cleared", v, 32'h0);
        rd(A_RST, v);  chk("R7 reset ctrl readback", v, 32'h1101);
        pulse(1);
        rd(A_STAT, v); chk("R5 edge not captured while held", v, 32'h0);
        wr(A_RST, 32'h1111);
        rd(A_EVM, v); chk("R5 event enable kept", v, 32'h1111);
        pulse(1); wait_cyc(1);
        chk("R5 irq resumes after release", 32'(irq_o), 1);
        rd(A_STAT, v); chk("R5 capture resumes", v, 32'h0010);
    endtask

    task automatic t_global();
        logic [31:0] v;
        wr(A_RST, 32'h1110);
        chk("R6 port A reset in global reset", 32'(port_a_rst_o), 1);
        chk("R6 port B reset in global reset", 32'(port_b_rst_o), 1);
        rd(A_STAT, v); chk("R6 status cleared", v, 32'h0);
        rd(A_EVM, v);  chk("R6 event enable cleared", v, 32'h0);
        rd(A_MSK, v);  chk("R6 mask cleared", v, 32'h0);
        chk("R6 irq low", 32'(irq_o), 0);
        wr(A_RST, 32'h1111);
        chk("R6 port A released", 32'(port_a_rst_o), 0);
        chk("R6 port B released", 32'(port_b_rst_o), 0);
    endtask

    task automatic t_port();
        logic [31:0] v;
        wr(A_RST, 32'h0111);
        chk("R7 port B reset from bit 12", 32'(port_b_rst_o), 1);
        chk("R7 port A untouched by bit 12", 32'(port_a_rst_o), 0);
        rd(A_RST, v); chk("R7 readback bit 12 low", v, 32'h0111);
        wr(A_RST, 32'h1011);
        chk("R7 port A reset from bit 8", 32'(port_a_rst_o), 1);
        chk("R7 port B released", 32'(port_b_rst_o), 0);
        wr(A_RST, 32'h1111);
    endtask

    task automatic t_upper();
        logic [31:0] v;
        wr(A_MSK, 32'hFF00_0000);
        rd(A_MSK, v); chk("R8 upper write bits ignored", v, 32'h0);
        wr(A_EVM, 32'hFFFF_FFFF);
        rd(A_EVM, v); chk("R8 undefined bits read zero", v, 32'h1111);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_edge();
        t_masks();
        t_clear();
        t_collision();
        t_int_reset();
        t_global();
        t_port();
        t_upper();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule